// File: doc/BRIEF.md
# Handshake Register Slice

This block sits on a point-to-point data link in which each word travels under a strobe/acknowledge handshake. It takes words from an upstream transmitter on its input side and hands them on to a downstream receiver on its output side. Every signal it presents on either side comes straight from a flop. This cuts any long combinational path that would otherwise run between the two parties. A word moves on a side at a rising clock edge only when that side's strobe and acknowledge are both high.

The slice stores at most two words: a head word, which is shown on the output, and a spare word, which absorbs the one extra beat that arrives while the downstream side stalls. The input acknowledge is raised only when a slot is free, so the slice never has to withdraw it before a word arrives. The output strobe is raised as soon as a word is stored and does not wait for the downstream acknowledge. When both neighbours stay ready, one word passes per clock with no gaps. The payload width is a parameter. The slice does not alter the data.

Top module: `hs_reg_slice`

## Requirements
- R1: A word is taken from the input at a rising edge where `in_stb` and `in_ack` are both high, and a word leaves at an edge where `out_stb` and `out_ack` are both high. No word moves at any other edge.
- R2: Once `out_stb` is high it stays high, and `out_data` stays unchanged, at every edge until a word leaves.
- R3: Once `in_ack` is high it stays high at every edge until a word is taken.
- R4: The slice holds at most two words. `in_ack` is high exactly when fewer than two words are stored. After two words are taken with no word leaving, `in_ack` is low.
- R5: `out_stb` is high exactly when at least one word is stored. It rises on the edge after the first word is taken, whatever `out_ack` does.
- R6: While `rst` is high, each rising edge drives `out_stb` and `in_ack` low and discards all stored words. On the first edge after `rst` falls, `in_ack` rises and `out_stb` stays low.
- R7: With `in_stb` and `out_ack` held high, one word passes on every cycle, and `in_ack` and `out_stb` stay high between words.
- R8: Words leave in the order in which they were taken, and no word is lost or repeated.
- R9: When a word is taken and another word leaves on the same edge, the number of stored words does not change, so `in_ack` and `out_stb` keep their values.
- R10: `out_stb`, `out_data` and `in_ack` come only from flops. A change on `in_stb`, `in_data` or `out_ack` does not alter them before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Payload offered by the upstream transmitter |
| in_stb | input | 1 | Upstream payload is valid |
| in_ack | output | 1 | Slice can take a word |
| out_data | output | DATA_W | Payload offered to the downstream receiver |
| out_stb | output | 1 | Output payload is valid |
| out_ack | input | 1 | Downstream receiver is ready |

## Verification
The in-line assertions check on every cycle that the output strobe and payload are held during a stall, that the input acknowledge is not withdrawn before a word arrives, that occupancy never goes above two, that occupancy holds when a word enters and leaves on the same edge, and that reset clears both handshake outputs. Word order and the one-word-per-clock rate of a continuous stream can be seen only across a whole scenario, so the bench shows them by matching the output sequence against the words it drove. The bench also changes inputs in the middle of a cycle, which is how it shows that the outputs are registered.

// File: rtl/hs_slice_pkg.sv
package hs_slice_pkg;

    // Source selection for the head (output) register
    typedef enum logic [1:0] {
        HEAD_HOLD = 2'd0,
        HEAD_IN   = 2'd1,
        HEAD_SKID = 2'd2
    } head_src_e;

    localparam int unsigned SLOTS   = 2;
    localparam int unsigned CNT_W   = $clog2(SLOTS + 1);

    // Registered control state
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out_stb;
        logic             in_ack;
    } ctrl_state_t;

endpackage

// File: rtl/hs_slice_ctrl.sv
module hs_slice_ctrl
    import hs_slice_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_stb,
    input  logic      out_ack,
    output logic      in_ack,
    output logic      out_stb,
    output head_src_e head_src,
    output logic      skid_ld
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    ctrl_state_t st_q, st_d;
    logic        take, give;

    always_comb begin
        take     = in_stb & st_q.in_ack;
        give     = st_q.out_stb & out_ack;
        st_d     = st_q;
        head_src = HEAD_HOLD;
        skid_ld  = 1'b0;

        // head register: refill from spare on drain when full,
        // otherwise straight from input when it becomes (or stays) the only word
        if (give && st_q.cnt == FULL) begin
            head_src = HEAD_SKID;
        end else if (take && (st_q.cnt == '0 || (st_q.cnt == ONE && give))) begin
            head_src = HEAD_IN;
        end

        // spare register captures the extra beat behind a stalled head
        skid_ld = take && ((st_q.cnt == ONE && !give) || (st_q.cnt == FULL && give));

        case ({take, give})
            2'b10:   st_d.cnt = st_q.cnt + ONE;
            2'b01:   st_d.cnt = st_q.cnt - ONE;
            default: st_d.cnt = st_q.cnt;
        endcase

        st_d.out_stb = (st_d.cnt != '0);
        st_d.in_ack  = (st_d.cnt != FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ack  = st_q.in_ack;
    assign out_stb = st_q.out_stb;

    // R4: occupancy bounded and acknowledge withdrawn when full
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt <= FULL) && ((st_q.cnt == FULL) -> !in_ack));

    // R3: acknowledge is kept until a word is taken
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (in_ack && !in_stb) |=> in_ack);

    // R9: simultaneous take and give leave occupancy unchanged
    p_count_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (in_stb && in_ack && out_stb && out_ack) |=> (in_ack && out_stb && $stable(st_q.cnt)));

    // R5: a taken word always yields a strobe on the next cycle
    p_stb_after_take_r5: assert property (@(posedge clk) disable iff (rst)
        (in_stb && in_ack) |=> out_stb);

    // R6: reset clears both handshake outputs
    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> (!in_ack && !out_stb));

endmodule

// File: rtl/hs_slice_store.sv
module hs_slice_store
    import hs_slice_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  head_src_e         head_src,
    input  logic              skid_ld,
    output logic [DATA_W-1:0] head_data
);

    logic [DATA_W-1:0] head_d, head_q;
    logic [DATA_W-1:0] skid_d, skid_q;

    always_comb begin
        head_d = head_q;
        skid_d = skid_q;
        case (head_src)
            HEAD_IN:   head_d = in_data;
            HEAD_SKID: head_d = skid_q;
            default:   head_d = head_q;
        endcase
        if (skid_ld) begin
            skid_d = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            skid_q <= '0;
        end else begin
            head_q <= head_d;
            skid_q <= skid_d;
        end
    end

    assign head_data = head_q;

endmodule

// File: rtl/hs_reg_slice.sv
module hs_reg_slice
    import hs_slice_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_stb,
    output logic              in_ack,
    output logic [DATA_W-1:0] out_data,
    output logic              out_stb,
    input  logic              out_ack
);

    head_src_e head_src;
    logic      skid_ld;

    hs_slice_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_stb   (in_stb),
        .out_ack  (out_ack),
        .in_ack   (in_ack),
        .out_stb  (out_stb),
        .head_src (head_src),
        .skid_ld  (skid_ld)
    );

    hs_slice_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .head_src  (head_src),
        .skid_ld   (skid_ld),
        .head_data (out_data)
    );

    // R2: stalled output keeps strobe and payload
    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (out_stb && !out_ack) |=> (out_stb && $stable(out_data)));

endmodule

// File: tb/tb_hs_reg_slice.sv
module tb_hs_reg_slice;

    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_stb = 1'b0;
    logic          in_ack;
    logic [DW-1:0] out_data;
    logic          out_stb;
    logic          out_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hs_reg_slice #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_stb(in_stb),
        .in_ack(in_ack), .out_data(out_data), .out_stb(out_stb), .out_ack(out_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // {exp_stb, exp_data, exp_ack, drv_stb, drv_data, drv_oack}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h11, 1'b0},
        {1'b1, 8'h11, 1'b1, 1'b1, 8'h22, 1'b0},
        {1'b1, 8'h11, 1'b0, 1'b1, 8'h33, 1'b0},
        {1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h22, 1'b1, 1'b1, 8'h33, 1'b1},
        {1'b1, 8'h33, 1'b1, 1'b1, 8'h44, 1'b1},
        {1'b1, 8'h44, 1'b1, 1'b0, 8'h00, 1'b0},
        {1'b1, 8'h44, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h55, 1'b1},
        {1'b1, 8'h55, 1'b1, 1'b1, 8'h66, 1'b0},
        {1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h66, 1'b1, 1'b1, 8'h77, 1'b1},
        {1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk("R6 stb in reset", 32'(out_stb), 0);
        chk("R6 ack in reset", 32'(in_ack), 0);
        rst = 1'b0;
        @(negedge clk);

        // vector table: R1 R2 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            chk("R5 out_stb", 32'(out_stb), 32'(VEC[i][19]));
            chk("R4 in_ack", 32'(in_ack), 32'(VEC[i][10]));
            if (VEC[i][19]) chk("R8 out_data", 32'(out_data), 32'(VEC[i][18:11]));
            in_stb  = VEC[i][9];
            in_data = VEC[i][8:1];
            out_ack = VEC[i][0];
            @(negedge clk);
        end

        // R7: continuous stream at one word per clock
        in_stb = 1'b1; out_ack = 1'b1; in_data = 8'h80;
        @(negedge clk);
        for (int k = 1; k <= 20; k++) begin
            chk("R7 stb kept", 32'(out_stb), 1);
            chk("R7 ack kept", 32'(in_ack), 1);
            chk("R7 R8 stream word", 32'(out_data), 32'(8'h80 + k - 1));
            in_data = 8'(8'h80 + k);
            @(negedge clk);
        end
        in_stb = 1'b0;
        @(negedge clk);
        chk("R7 drained", 32'(out_stb), 0);

        // R3 and R2: one word stored, no upstream strobe, downstream stalled
        in_stb = 1'b1; in_data = 8'hA1; out_ack = 1'b0;
        @(negedge clk);
        in_stb = 1'b0; in_data = 8'hEE;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R3 ack held", 32'(in_ack), 1);
            chk("R2 data held", 32'(out_data), 32'(8'hA1));
            chk("R1 no transfer without stb", 32'(out_stb), 1);
        end

        // R4 fill, then R10 mid-cycle input changes
        in_stb = 1'b1; in_data = 8'hA2;
        @(negedge clk);
        in_stb = 1'b0;
        chk("R4 full drops ack", 32'(in_ack), 0);
        out_ack = 1'b1; in_data = 8'h5A;
        #1;
        chk("R10 ack registered", 32'(in_ack), 0);
        chk("R10 data registered", 32'(out_data), 32'(8'hA1));
        @(negedge clk);
        chk("R8 second word", 32'(out_data), 32'(8'hA2));
        chk("R4 ack after drain", 32'(in_ack), 1);
        out_ack = 1'b0;

        // R6: reset with stored words discards them
        in_stb = 1'b1; in_data = 8'hB1;
        @(negedge clk);
        in_stb = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R6 stb cleared", 32'(out_stb), 0);
        chk("R6 ack cleared", 32'(in_ack), 0);
        rst = 1'b0; out_ack = 1'b1;
        @(negedge clk);
        chk("R6 ack after release", 32'(in_ack), 1);
        chk("R6 no stale word", 32'(out_stb), 0);

        done = 1'b1;
        finish_run();
    end

endmodule